// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit sits between a CPU's logical address bus and the main memory. A logical address in the lower 4 MB is split into a 10-bit page index and a 12-bit offset. The page index selects one of 1024 map entries of 16 bits each. The entry's physical page number replaces the index in the outgoing address. Addresses at or above 4 MB belong to I/O and other windows. They leave the unit unchanged.

Each map entry also carries two page status bits, bits 14 and 13. Nonzero status means the page is present. When the access strobe is high and the page is present, the unit marks the page on the clock edge that ends the access. A read sets the accessed bit (bit 14). A write sets both bit 14 and the dirty bit (bit 13). A page with status 00 is left as it is.

Software reaches the map through a CPU-side port of 16-bit words with big-endian byte lanes. The even byte address of a word is the high byte, which holds the status bits. A software write and a status mark aimed at the same entry in the same cycle resolve in favour of software. An access is classified as idle, pass-through, translated read or translated write. A combinational `unique case` over that kind decides the write-back. The map's only sequential state is the entry array itself.

Top module: `page_xlate`

## Requirements
- R1: After reset every map entry reads 0x0000, so a logical address below 0x400000 maps to physical page 0 with its offset kept.
- R2: A logical address at or above 0x400000 appears on `phys_addr` unchanged, in the same cycle.
- R3: For a logical address below 0x400000, `phys_addr` is {2'b00, entry[9:0], addr[11:0]} in the same cycle. The entry index is addr[21:12], and entry bits 15..10 have no effect on the address.
- R4: A strobed read of a present page (entry bits 14:13 not 00) sets entry bit 14 at the next rising edge and leaves all other bits unchanged.
- R5: A strobed write of a present page sets entry bits 14 and 13 at the next rising edge and leaves all other bits unchanged.
- R6: An access to an absent page (entry bits 14:13 = 00) leaves the entry unchanged.
- R7: A pass-through access (address at or above 0x400000) changes no map entry, including the entry that addr[21:12] would select.
- R8: With `acc_valid` low, no map entry changes, whatever the address and direction inputs carry.
- R9: With `map_cs` and `map_we` high, the word at `map_idx` is written at the rising edge, lane by lane. `map_be[1]` writes bits 15:8 (the even byte address) and `map_be[0]` writes bits 7:0. `map_rdata` always shows the word at `map_idx` combinationally.
- R10: When a software write and a status mark target the same entry in one cycle, the entry takes the software data and the mark is dropped. When they target different entries, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the map |
| acc_valid | input | 1 | Access strobe; qualifies the status mark |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 24 | Logical byte address |
| phys_addr | output | 24 | Translated or passed-through physical address |
| map_cs | input | 1 | Software map port select |
| map_we | input | 1 | Software map write enable |
| map_idx | input | 10 | Map entry index for software read and write |
| map_be | input | 2 | Byte lane enables, bit 1 = high byte |
| map_wdata | input | 16 | Software write data |
| map_rdata | output | 16 | Entry at `map_idx`, combinational |

## Verification
`phys_addr` and `map_rdata` are combinational, so they are due in the same cycle as the inputs that set them. Every change to the map, whether a status mark or a software write, appears one rising edge later. The bench drives inputs on the falling edge and samples the address output 1 ns after that. It reads an entry back only after the falling edge that follows the updating rising edge. That is why every expected value is compared at the point where it is due and never earlier.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

    // Positions of the status bits; software decodes them, so they are fixed.
    parameter int ST_ACC_BIT   = 14;
    parameter int ST_DIRTY_BIT = 13;

    typedef enum logic [1:0] {
        AK_IDLE  = 2'd0,
        AK_PASS  = 2'd1,
        AK_READ  = 2'd2,
        AK_WRITE = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/page_xlate_decode.sv
module page_xlate_decode
    import page_xlate_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 10,
    parameter int OFFS_W = 12,
    parameter int PPN_W  = 10
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PPN_W-1:0]  ent_ppn,
    output logic [IDX_W-1:0]  page_idx,
    output logic [ADDR_W-1:0] phys_addr,
    output acc_kind_e         kind
);
    localparam int LOW_W = IDX_W + OFFS_W;
    localparam int HI_W  = ADDR_W - LOW_W;
    localparam int PAD_W = ADDR_W - PPN_W - OFFS_W;

    logic in_low;

    always_comb begin
        in_low   = (acc_addr[ADDR_W-1:LOW_W] == {HI_W{1'b0}});
        page_idx = acc_addr[LOW_W-1:OFFS_W];
        if (in_low)
            phys_addr = {{PAD_W{1'b0}}, ent_ppn, acc_addr[OFFS_W-1:0]};
        else
            phys_addr = acc_addr;

        if (!acc_valid)
            kind = AK_IDLE;
        else if (!in_low)
            kind = AK_PASS;
        else if (acc_write)
            kind = AK_WRITE;
        else
            kind = AK_READ;
    end
endmodule

// File: rtl/page_xlate_marker.sv
module page_xlate_marker
    import page_xlate_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int ENT_W = 16
) (
    input  acc_kind_e         kind,
    input  logic [ENT_W-1:0]  entry,
    input  logic [IDX_W-1:0]  page_idx,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [ENT_W-1:0]  upd_data
);
    logic present;
    logic collide;

    always_comb begin
        present  = entry[ST_ACC_BIT] | entry[ST_DIRTY_BIT];
        collide  = sw_wr && (sw_idx == page_idx);
        upd_idx  = page_idx;
        upd_data = entry;
        upd_en   = 1'b0;
        unique case (kind)
            AK_IDLE, AK_PASS: begin
                upd_en = 1'b0;
            end
            AK_READ: begin
                upd_en                = present && !collide;
                upd_data[ST_ACC_BIT]  = 1'b1;
            end
            AK_WRITE: begin
                upd_en                 = present && !collide;
                upd_data[ST_ACC_BIT]   = 1'b1;
                upd_data[ST_DIRTY_BIT] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/page_xlate_store.sv
module page_xlate_store #(
    parameter int IDX_W = 10,
    parameter int ENT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     xl_idx,
    output logic [ENT_W-1:0]     xl_entry,
    input  logic                 upd_en,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic [ENT_W-1:0]     upd_data,
    input  logic                 sw_wr,
    input  logic [IDX_W-1:0]     sw_idx,
    input  logic [ENT_W/8-1:0]   sw_be,
    input  logic [ENT_W-1:0]     sw_wdata,
    output logic [ENT_W-1:0]     sw_rdata
);
    localparam int PAGES = 1 << IDX_W;
    localparam int LANES = ENT_W / 8;

    logic [ENT_W-1:0] mem [PAGES];

    assign xl_entry = mem[xl_idx];
    assign sw_rdata = mem[sw_idx];

    // The status mark goes first; a software lane write in the same
    // cycle overrides it (the marker already drops same-entry marks).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++)
                mem[p] <= '0;
        end else begin
            if (upd_en)
                mem[upd_idx] <= upd_data;
            if (sw_wr) begin
                for (int b = 0; b < LANES; b++)
                    if (sw_be[b])
                        mem[sw_idx][b*8 +: 8] <= sw_wdata[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 10,
    parameter int OFFS_W = 12,
    parameter int ENT_W  = 16,
    parameter int PPN_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    output logic [ADDR_W-1:0]    phys_addr,
    input  logic                 map_cs,
    input  logic                 map_we,
    input  logic [IDX_W-1:0]     map_idx,
    input  logic [ENT_W/8-1:0]   map_be,
    input  logic [ENT_W-1:0]     map_wdata,
    output logic [ENT_W-1:0]     map_rdata
);
    logic [IDX_W-1:0] page_idx;
    logic [ENT_W-1:0] xl_entry;
    acc_kind_e        kind;
    logic             sw_wr;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic [ENT_W-1:0] upd_data;

    assign sw_wr = map_cs & map_we;

    page_xlate_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W), .PPN_W(PPN_W)
    ) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .ent_ppn   (xl_entry[PPN_W-1:0]),
        .page_idx  (page_idx),
        .phys_addr (phys_addr),
        .kind      (kind)
    );

    page_xlate_marker #(
        .IDX_W(IDX_W), .ENT_W(ENT_W)
    ) u_marker (
        .kind     (kind),
        .entry    (xl_entry),
        .page_idx (page_idx),
        .sw_wr    (sw_wr),
        .sw_idx   (map_idx),
        .upd_en   (upd_en),
        .upd_idx  (upd_idx),
        .upd_data (upd_data)
    );

    page_xlate_store #(
        .IDX_W(IDX_W), .ENT_W(ENT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .xl_idx   (page_idx),
        .xl_entry (xl_entry),
        .upd_en   (upd_en),
        .upd_idx  (upd_idx),
        .upd_data (upd_data),
        .sw_wr    (sw_wr),
        .sw_idx   (map_idx),
        .sw_be    (map_be),
        .sw_wdata (map_wdata),
        .sw_rdata (map_rdata)
    );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk
    import page_xlate_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 10,
    parameter int OFFS_W = 12,
    parameter int ENT_W  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic [ADDR_W-1:0]    phys_addr,
    input logic                 map_cs,
    input logic                 map_we,
    input logic [IDX_W-1:0]     map_idx,
    input logic [ENT_W/8-1:0]   map_be,
    input logic [ENT_W-1:0]     xl_entry,
    input logic                 upd_en,
    input logic [IDX_W-1:0]     upd_idx,
    input logic [ENT_W-1:0]     upd_data
);
    localparam int LOW_W = IDX_W + OFFS_W;

    logic low, present, collide;
    logic [ENT_W-1:0] rd_mark, wr_mark;

    always_comb begin
        low     = (acc_addr >> LOW_W) == '0;
        present = xl_entry[ST_ACC_BIT] || xl_entry[ST_DIRTY_BIT];
        collide = map_cs && map_we && (map_idx == acc_addr[LOW_W-1:OFFS_W]);
        rd_mark = xl_entry;
        rd_mark[ST_ACC_BIT] = 1'b1;
        wr_mark = rd_mark;
        wr_mark[ST_DIRTY_BIT] = 1'b1;
    end

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !low |-> phys_addr == acc_addr);

    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFFS_W-1:0] == acc_addr[OFFS_W-1:0]);

    p_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> upd_idx == acc_addr[LOW_W-1:OFFS_W]);

    p_read_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && low && present && !collide)
        |-> (upd_en && upd_data == rd_mark));

    p_write_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && low && present && !collide)
        |-> (upd_en && upd_data == wr_mark));

    p_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !present |-> !upd_en);

    p_pass_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !low |-> !upd_en);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !upd_en);

    p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> !upd_en);
endmodule

bind page_xlate page_xlate_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W), .ENT_W(ENT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .phys_addr (phys_addr),
    .map_cs    (map_cs),
    .map_we    (map_we),
    .map_idx   (map_idx),
    .map_be    (map_be),
    .xl_entry  (xl_entry),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_data  (upd_data)
);

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [23:0] phys_addr;
    logic        map_cs = 1'b0;
    logic        map_we = 1'b0;
    logic [9:0]  map_idx = '0;
    logic [1:0]  map_be = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    page_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .phys_addr(phys_addr),
        .map_cs(map_cs), .map_we(map_we), .map_idx(map_idx), .map_be(map_be),
        .map_wdata(map_wdata), .map_rdata(map_rdata)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic sw_write(logic [9:0] idx, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        map_cs = 1'b1; map_we = 1'b1; map_idx = idx; map_be = be; map_wdata = d;
        @(negedge clk);
        map_cs = 1'b0; map_we = 1'b0; map_be = '0;
    endtask

    task automatic sw_read(logic [9:0] idx, output logic [15:0] d);
        @(negedge clk);
        map_idx = idx;
        #1 d = map_rdata;
    endtask

    // One strobed access; phys sampled in the access cycle, strobe dropped after the edge.
    task automatic access(logic [23:0] a, logic wr, logic strobe, output logic [23:0] pa);
        @(negedge clk);
        acc_addr = a; acc_write = wr; acc_valid = strobe;
        #1 pa = phys_addr;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d; logic [23:0] pa;
        sw_read(10'd0, d);   check("R1 entry 0 after reset", d, 16'h0000);
        sw_read(10'h3FF, d); check("R1 entry 1023 after reset", d, 16'h0000);
        access(24'h123456, 1'b0, 1'b0, pa);
        check("R1 page 0 translation", pa, 24'h000456);
    endtask

    task automatic t_lanes();
        logic [15:0] d;
        sw_write(10'd3, 2'b11, 16'h2005);
        sw_read(10'd3, d); check("R9 full word write", d, 16'h2005);
        sw_write(10'd3, 2'b10, 16'hAB99);
        sw_read(10'd3, d); check("R9 high lane only", d, 16'hAB05);
        sw_write(10'd3, 2'b01, 16'h1177);
        sw_read(10'd3, d); check("R9 low lane only", d, 16'hAB77);
        sw_write(10'd3, 2'b00, 16'h0000);
        sw_read(10'd3, d); check("R9 no lanes enabled", d, 16'hAB77);
    endtask

    task automatic t_read_mark();
        logic [15:0] d; logic [23:0] pa;
        sw_write(10'h123, 2'b11, 16'h2155);
        access(24'h123456, 1'b0, 1'b1, pa);
        check("R3 translated address", pa, 24'h155456);
        sw_read(10'h123, d); check("R4 read sets bit 14", d, 16'h6155);
    endtask

    task automatic t_write_mark();
        logic [15:0] d; logic [23:0] pa;
        sw_write(10'h010, 2'b11, 16'h4011);
        access(24'h010FFF, 1'b1, 1'b1, pa);
        check("R3 translated address at page end", pa, 24'h011FFF);
        sw_read(10'h010, d); check("R5 write sets bits 14 and 13", d, 16'h6011);
    endtask

    task automatic t_absent();
        logic [15:0] d; logic [23:0] pa;
        sw_write(10'h3FF, 2'b11, 16'h9C07);
        access(24'h3FFABC, 1'b1, 1'b1, pa);
        check("R3 upper entry bits ignored", pa, 24'h007ABC);
        sw_read(10'h3FF, d); check("R6 absent page unchanged", d, 16'h9C07);
    endtask

    task automatic t_pass();
        logic [15:0] d; logic [23:0] pa;
        sw_write(10'h005, 2'b11, 16'h2000);
        access(24'h405000, 1'b1, 1'b1, pa);
        check("R2 pass-through 0x405000", pa, 24'h405000);
        access(24'hFFFFFF, 1'b0, 1'b1, pa);
        check("R2 pass-through 0xFFFFFF", pa, 24'hFFFFFF);
        access(24'h400000, 1'b0, 1'b1, pa);
        check("R2 pass-through boundary", pa, 24'h400000);
        sw_read(10'h005, d); check("R7 aliased entry untouched", d, 16'h2000);
    endtask

    task automatic t_idle();
        logic [15:0] d; logic [23:0] pa;
        sw_write(10'h020, 2'b11, 16'h2001);
        access(24'h020000, 1'b1, 1'b0, pa);
        check("R8 address still translated", pa, 24'h001000);
        sw_read(10'h020, d); check("R8 no strobe no mark", d, 16'h2001);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        sw_write(10'h030, 2'b11, 16'h2003);
        @(negedge clk);
        acc_addr = 24'h030000; acc_write = 1'b1; acc_valid = 1'b1;
        map_cs = 1'b1; map_we = 1'b1; map_idx = 10'h030; map_be = 2'b11; map_wdata = 16'h2033;
        @(negedge clk);
        acc_valid = 1'b0; map_cs = 1'b0; map_we = 1'b0; map_be = '0;
        sw_read(10'h030, d); check("R10 software write wins", d, 16'h2033);

        sw_write(10'h040, 2'b11, 16'h2004);
        @(negedge clk);
        acc_addr = 24'h040000; acc_write = 1'b0; acc_valid = 1'b1;
        map_cs = 1'b1; map_we = 1'b1; map_idx = 10'h041; map_be = 2'b11; map_wdata = 16'h1234;
        @(negedge clk);
        acc_valid = 1'b0; map_cs = 1'b0; map_we = 1'b0; map_be = '0;
        sw_read(10'h040, d); check("R10 mark on other entry kept", d, 16'h6004);
        sw_read(10'h041, d); check("R10 software write on other entry kept", d, 16'h1234);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_read_mark();
        t_write_mark();
        t_absent();
        t_pass();
        t_idle();
        t_collide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule